// File: doc/BRIEF.md
# Parametric floating-point multiplier

This block multiplies two binary floating-point numbers whose exponent and fraction widths are set by parameters. The product and its exception flags are formed by combinational logic alone. No register stands between operands and results, so the block can sit inside any pipeline stage its host chooses. Each operand word holds a sign bit at the top, then a biased exponent field, then the fraction field.

Operands are first classified and unpacked. Subnormal operands are normalized by a leading-zero count, and that count lowers their exponent. The significands are multiplied at full width and the product is normalized by at most one position. Products below the normal range are shifted right into the subnormal range, and the bits shifted out are collected into a sticky bit. Rounding is set at elaboration time: either round to nearest with ties to even, or truncation. A final selection stage handles NaNs, infinities and zeros and raises the overflow, underflow and invalid-operation flags.

Top module: `fpmul_param`

## Requirements
- R1: An operand or result word is laid out MSB first as the sign bit, then an EXP_W-bit exponent field biased by 2^(EXP_W-1)-1, then an FRAC_W-bit fraction. An exponent field of 0 means zero or subnormal, and an exponent field of all ones means infinity or NaN.
- R2: Every non-NaN result, including zeros and infinities, has a sign equal to the XOR of the two operand signs.
- R3: With ROUND_NEAREST=1, a finite nonzero product is rounded to the nearest representable value. On a tie it goes to the value with an even fraction LSB.
- R4: With ROUND_NEAREST=0, a finite nonzero product is truncated toward zero before it is encoded.
- R5: A subnormal operand (exponent field 0, fraction f nonzero) is taken at its exact value f·2^(1-bias-FRAC_W).
- R6: A product below 2^(1-bias) is delivered as a subnormal, after rounding at the subnormal quantum. It may round to a signed zero or up to the smallest normal value (exponent field 1).
- R7: When the rounded exponent field would reach all ones, the result is a signed infinity and flag_ovf is 1.
- R8: flag_unf is 1 only when the exact product of finite nonzero operands is below 2^(1-bias) and cannot be represented exactly. A tiny exact product leaves it at 0.
- R9: flag_inv is 1 when either operand is a signaling NaN, or when zero is multiplied by infinity. In both cases the result is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0. A NaN whose fraction MSB is 0 counts as signaling.
- R10: When either operand is a quiet NaN (fraction MSB 1) and no invalid case applies, the result is the canonical quiet NaN and no flag is raised.
- R11: Infinity times a nonzero non-NaN value gives a signed infinity. Zero times a finite value gives a signed zero. Neither case raises a flag.
- R12: The product and flags depend only on the present operand values, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| prod | output | 1+EXP_W+FRAC_W | Encoded product |
| flag_ovf | output | 1 | Result overflowed to infinity |
| flag_unf | output | 1 | Result is tiny and inexact |
| flag_inv | output | 1 | Invalid operation, quiet NaN returned |

## Verification
All results are combinational, so each product and flag is due in the same cycle its operands are applied, with zero register delay. The bench changes the operands just after a rising edge and reads the outputs at the following falling edge, half a period later. No check ever waits on an edge that the design does not have. Two directed checks compare the outputs a single time step after the operands change, which shows that no clock is needed. The sweep covers every operand pair of an 8-bit configuration in both rounding variants.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

    // Classification of one unpacked operand
    typedef enum logic [2:0] {
        OPK_ZERO,
        OPK_SUB,
        OPK_NORM,
        OPK_INF,
        OPK_QNAN,
        OPK_SNAN
    } opkind_e;

    // Exception flags carried to the output stage
    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
    } fpm_flags_t;

    function automatic logic kind_is_nan(opkind_e k);
        return (k == OPK_QNAN) || (k == OPK_SNAN);
    endfunction

    function automatic int bias_of(int exp_w);
        return (1 << (exp_w - 1)) - 1;
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int XW     = 16
) (
    input  logic [EXP_W+FRAC_W:0]  word,
    output opkind_e                kind,
    output logic                   sign,
    output logic [FRAC_W:0]        sig,
    output logic signed [XW-1:0]   exp_unb
);
    localparam int BIAS = bias_of(EXP_W);
    localparam int LZW  = $clog2(FRAC_W + 2);

    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic [FRAC_W:0]   ext;
    logic [LZW-1:0]    lz;

    assign sign   = word[EXP_W+FRAC_W];
    assign efield = word[EXP_W+FRAC_W-1:FRAC_W];
    assign ffield = word[FRAC_W-1:0];
    assign ext    = {1'b0, ffield};

    // Leading zeros of the fraction with its hidden zero prepended:
    // the highest set bit wins because it is visited last.
    always_comb begin
        lz = '0;
        for (int i = 0; i <= FRAC_W; i++) begin
            if (ext[i]) lz = LZW'(FRAC_W - i);
        end
    end

    always_comb begin
        if (efield == '0) begin
            kind = (ffield == '0) ? OPK_ZERO : OPK_SUB;
        end else if (efield == {EXP_W{1'b1}}) begin
            if (ffield == '0)          kind = OPK_INF;
            else if (ffield[FRAC_W-1]) kind = OPK_QNAN;
            else                       kind = OPK_SNAN;
        end else begin
            kind = OPK_NORM;
        end
    end

    // Significand with its leading one at bit FRAC_W, and the matching
    // unbiased exponent.
    always_comb begin
        if (efield == '0) begin
            sig     = ext << lz;
            exp_unb = XW'(1 - BIAS - int'(lz));
        end else begin
            sig     = {1'b1, ffield};
            exp_unb = XW'(int'(efield) - BIAS);
        end
    end

endmodule

// File: rtl/fpm_sigmul.sv
`timescale 1ns/1ps
module fpm_sigmul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int XW     = 16
) (
    input  logic [FRAC_W:0]        sig_a,
    input  logic [FRAC_W:0]        sig_b,
    input  logic signed [XW-1:0]   exp_a,
    input  logic signed [XW-1:0]   exp_b,
    output logic [FRAC_W:0]        keep,
    output logic                   guard,
    output logic                   sticky,
    output logic                   tiny,
    output logic signed [XW-1:0]   be
);
    localparam int BIAS = bias_of(EXP_W);
    localparam int PW   = 2 * FRAC_W + 2;
    localparam int SHW  = $clog2(PW + 2);
    localparam int SMAX = PW + 1;

    logic [PW-1:0]   full;
    logic [PW-1:0]   pn;
    logic            top;
    int              be_i;
    logic [SHW-1:0]  sh;
    logic [2*PW-1:0] wide;

    assign full = PW'(sig_a) * PW'(sig_b);

    always_comb begin
        top  = full[PW-1];
        pn   = top ? full : (full << 1);
        be_i = int'(exp_a) + int'(exp_b) + BIAS + (top ? 1 : 0);
        if (be_i >= 1) begin
            tiny = 1'b0;
            sh   = '0;
        end else begin
            tiny = 1'b1;
            sh   = ((1 - be_i) > SMAX) ? SHW'(SMAX) : SHW'(1 - be_i);
        end
        // Denormalizing shift; a zero shift is the normal-range case.
        wide   = {pn, {PW{1'b0}}} >> sh;
        keep   = wide[2*PW-1 -: FRAC_W+1];
        guard  = wide[2*PW-FRAC_W-2];
        sticky = |wide[2*PW-FRAC_W-3:0];
        be     = XW'(be_i);
    end

endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
    import fpm_pkg::*;
#(
    parameter int EXP_W         = 8,
    parameter int FRAC_W        = 23,
    parameter int XW            = 16,
    parameter int ROUND_NEAREST = 1
) (
    input  logic [FRAC_W:0]        keep,
    input  logic                   guard,
    input  logic                   sticky,
    input  logic                   tiny,
    input  logic signed [XW-1:0]   be,
    output logic [EXP_W-1:0]       efield,
    output logic [FRAC_W-1:0]      frac,
    output logic                   ovf,
    output logic                   unf
);
    localparam int EMAX = (1 << EXP_W) - 1;

    logic            inc;
    logic [FRAC_W+1:0] sum;
    int              e_i;

    generate
        if (ROUND_NEAREST != 0) begin : g_nearest
            assign inc = guard & (sticky | keep[0]);
        end else begin : g_chop
            assign inc = 1'b0;
        end
    endgenerate

    assign sum = {1'b0, keep} + (FRAC_W+2)'(inc);

    always_comb begin
        if (tiny) begin
            // A carry into bit FRAC_W lifts the subnormal to the smallest normal.
            e_i  = sum[FRAC_W] ? 1 : 0;
            frac = sum[FRAC_W-1:0];
        end else begin
            e_i  = int'(be) + (sum[FRAC_W+1] ? 1 : 0);
            frac = sum[FRAC_W+1] ? '0 : sum[FRAC_W-1:0];
        end
        ovf    = !tiny && (e_i >= EMAX);
        unf    = tiny && (guard || sticky);
        efield = EXP_W'(e_i);
    end

endmodule

// File: rtl/fpmul_param.sv
`timescale 1ns/1ps
module fpmul_param
    import fpm_pkg::*;
#(
    parameter int EXP_W         = 8,
    parameter int FRAC_W        = 23,
    parameter int ROUND_NEAREST = 1
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic [EXP_W+FRAC_W:0] prod,
    output logic                  flag_ovf,
    output logic                  flag_unf,
    output logic                  flag_inv
);
    localparam int W  = 1 + EXP_W + FRAC_W;
    localparam int XW = EXP_W + $clog2(FRAC_W + 2) + 3;
    localparam logic [W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

    logic [W-1:0]          opw  [2];
    opkind_e               kind [2];
    logic                  sgn  [2];
    logic [FRAC_W:0]       sig  [2];
    logic signed [XW-1:0]  xun  [2];

    assign opw[0] = op_a;
    assign opw[1] = op_b;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_unp
            fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_unpack (
                .word    (opw[g]),
                .kind    (kind[g]),
                .sign    (sgn[g]),
                .sig     (sig[g]),
                .exp_unb (xun[g])
            );
        end
    endgenerate

    logic [FRAC_W:0]       m_keep;
    logic                  m_guard, m_sticky, m_tiny;
    logic signed [XW-1:0]  m_be;

    fpm_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_sigmul (
        .sig_a  (sig[0]),
        .sig_b  (sig[1]),
        .exp_a  (xun[0]),
        .exp_b  (xun[1]),
        .keep   (m_keep),
        .guard  (m_guard),
        .sticky (m_sticky),
        .tiny   (m_tiny),
        .be     (m_be)
    );

    logic [EXP_W-1:0]  r_ef;
    logic [FRAC_W-1:0] r_frac;
    logic              r_ovf, r_unf;

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW),
                .ROUND_NEAREST(ROUND_NEAREST)) u_round (
        .keep   (m_keep),
        .guard  (m_guard),
        .sticky (m_sticky),
        .tiny   (m_tiny),
        .be     (m_be),
        .efield (r_ef),
        .frac   (r_frac),
        .ovf    (r_ovf),
        .unf    (r_unf)
    );

    logic       nan_any, snan_any, inf_any, zero_any, rsign;
    fpm_flags_t fl;

    assign nan_any  = kind_is_nan(kind[0]) || kind_is_nan(kind[1]);
    assign snan_any = (kind[0] == OPK_SNAN) || (kind[1] == OPK_SNAN);
    assign inf_any  = (kind[0] == OPK_INF)  || (kind[1] == OPK_INF);
    assign zero_any = (kind[0] == OPK_ZERO) || (kind[1] == OPK_ZERO);
    assign rsign    = sgn[0] ^ sgn[1];

    // Special operands take priority over the arithmetic path.
    always_comb begin
        fl = '0;
        if (snan_any || (zero_any && inf_any)) begin
            prod   = QNAN_WORD;
            fl.inv = 1'b1;
        end else if (nan_any) begin
            prod = QNAN_WORD;
        end else if (inf_any) begin
            prod = {rsign, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (zero_any) begin
            prod = {rsign, {(W-1){1'b0}}};
        end else if (r_ovf) begin
            prod   = {rsign, EXP_ONES, {FRAC_W{1'b0}}};
            fl.ovf = 1'b1;
        end else begin
            prod   = {rsign, r_ef, r_frac};
            fl.unf = r_unf;
        end
    end

    assign flag_ovf = fl.ovf;
    assign flag_unf = fl.unf;
    assign flag_inv = fl.inv;

endmodule

// File: rtl/fpmul_param_chk.sv
`timescale 1ns/1ps
module fpmul_param_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic [EXP_W+FRAC_W:0] prod,
    input logic                  flag_ovf,
    input logic                  flag_unf,
    input logic                  flag_inv
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, b_nan, p_nan, a_zero, b_fin, p_inf;

    assign a_nan  = (op_a[W-2:FRAC_W] == '1) && (op_a[FRAC_W-1:0] != '0);
    assign b_nan  = (op_b[W-2:FRAC_W] == '1) && (op_b[FRAC_W-1:0] != '0);
    assign p_nan  = (prod[W-2:FRAC_W] == '1) && (prod[FRAC_W-1:0] != '0);
    assign p_inf  = (prod[W-2:FRAC_W] == '1) && (prod[FRAC_W-1:0] == '0);
    assign a_zero = (op_a[W-2:0] == '0);
    assign b_fin  = (op_b[W-2:FRAC_W] != '1);

    always_comb begin
        if (flag_ovf) begin
            AST_OVF_GIVES_INF: assert (p_inf) else $error("overflow without infinity"); // R7
        end
        if (flag_inv) begin
            AST_INV_GIVES_QNAN: assert (prod == QN) else $error("invalid without canonical NaN"); // R9
        end
        if (a_nan || b_nan) begin
            AST_NAN_IN_QNAN_OUT: assert (prod == QN) else $error("NaN operand not canonicalised"); // R10
        end
        if (!p_nan) begin
            AST_SIGN_IS_XOR: assert (prod[W-1] == (op_a[W-1] ^ op_b[W-1])) else $error("sign mismatch"); // R2
        end
        if (a_zero && b_fin) begin
            AST_ZERO_TIMES_FINITE: assert (prod[W-2:0] == '0 && !flag_ovf && !flag_unf && !flag_inv) else $error("zero product wrong"); // R11
        end
        AST_ONE_FLAG_AT_MOST: assert ($onehot0({flag_ovf, flag_unf, flag_inv})) else $error("flags overlap"); // R8
    end

endmodule

bind fpmul_param fpmul_param_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .prod     (prod),
    .flag_ovf (flag_ovf),
    .flag_unf (flag_unf),
    .flag_inv (flag_inv)
);

// File: tb/fpmul_param_tb_top.sv
`timescale 1ns/1ps
module fpmul_param_tb_top;
    localparam int EW   = 4;
    localparam int MW   = 3;
    localparam int W    = 1 + EW + MW;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMAX = (1 << EW) - 1;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] p_rne, p_trn;
    logic ov_rne, un_rne, iv_rne, ov_trn, un_trn, iv_trn;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    fpmul_param #(.EXP_W(EW), .FRAC_W(MW), .ROUND_NEAREST(1)) dut_i (
        .op_a(a), .op_b(b), .prod(p_rne),
        .flag_ovf(ov_rne), .flag_unf(un_rne), .flag_inv(iv_rne)
    );

    fpmul_param #(.EXP_W(EW), .FRAC_W(MW), .ROUND_NEAREST(0)) dut_trunc_i (
        .op_a(a), .op_b(b), .prod(p_trn),
        .flag_ovf(ov_trn), .flag_unf(un_trn), .flag_inv(iv_trn)
    );

    // Exact arithmetic model: returns {ovf, unf, inv, word}
    function automatic logic [W+2:0] ref_mul(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input bit rne);
        logic [W-1:0] qn;
        int ex, ey, fx, fy, mx, my, xx, xy, m, e, p, q, s, r, ef;
        bit g, st, tiny, sgn, nx, ny, snx, sny, ix, iy, zx, zy;
        qn  = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
        ex  = int'(x[W-2:MW]);  fx = int'(x[MW-1:0]);
        ey  = int'(y[W-2:MW]);  fy = int'(y[MW-1:0]);
        sgn = x[W-1] ^ y[W-1];
        nx  = (ex == EMAX) && (fx != 0);
        ny  = (ey == EMAX) && (fy != 0);
        snx = nx && (fx < (1 << (MW - 1)));
        sny = ny && (fy < (1 << (MW - 1)));
        ix  = (ex == EMAX) && (fx == 0);
        iy  = (ey == EMAX) && (fy == 0);
        zx  = (ex == 0) && (fx == 0);
        zy  = (ey == 0) && (fy == 0);
        if (snx || sny || (ix && zy) || (zx && iy)) return {3'b001, qn};
        if (nx || ny) return {3'b000, qn};
        if (ix || iy) return {3'b000, sgn, {EW{1'b1}}, {MW{1'b0}}};
        if (zx || zy) return {3'b000, sgn, {(W-1){1'b0}}};
        mx = (ex == 0) ? fx : ((1 << MW) + fx);
        my = (ey == 0) ? fy : ((1 << MW) + fy);
        xx = ((ex == 0) ? 1 : ex) - BIAS - MW;
        xy = ((ey == 0) ? 1 : ey) - BIAS - MW;
        m  = mx * my;
        e  = xx + xy;
        p  = 0;
        for (int i = 0; i < 16; i++) if (((m >> i) & 1) != 0) p = i;
        q = p + e - MW;
        if (q < 1 - BIAS - MW) q = 1 - BIAS - MW;
        s = q - e;
        if (s <= 0) begin
            r = m << (-s); g = 1'b0; st = 1'b0;
        end else begin
            r  = m >> s;
            g  = ((m >> (s - 1)) & 1) != 0;
            st = (m & ((1 << (s - 1)) - 1)) != 0;
        end
        tiny = (p + e) < (1 - BIAS);
        if (rne && g && (st || ((r & 1) != 0))) r++;
        if (r == (1 << (MW + 1))) begin r = r >> 1; q++; end
        if (r >= (1 << MW)) begin ef = q + MW + BIAS; r = r - (1 << MW); end
        else ef = 0;
        if (ef >= EMAX) return {3'b100, sgn, {EW{1'b1}}, {MW{1'b0}}};
        return {1'b0, tiny && (g || st), 1'b0, sgn, EW'(ef), MW'(r)};
    endfunction

    function automatic string req_tag(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic [W+2:0] expv, input logic [W+2:0] got,
                                      input bit rne);
        bit nanop, special, subop;
        nanop   = ((x[W-2:MW] == '1) && (x[MW-1:0] != '0)) ||
                  ((y[W-2:MW] == '1) && (y[MW-1:0] != '0));
        special = (x[W-2:MW] == '1) || (y[W-2:MW] == '1) ||
                  (x[W-2:0] == '0) || (y[W-2:0] == '0);
        subop   = (x[W-2:MW] == '0) || (y[W-2:MW] == '0);
        if ((got ^ expv) == {3'b000, 1'b1, {(W-1){1'b0}}}) return "R2";
        if (expv[W]) return "R9";
        if (nanop) return "R10";
        if (special) return "R11";
        if (expv[W+2]) return "R7";
        if (expv[W+1]) return "R8";
        if (expv[W-2:MW] == '0) return "R6";
        if (subop) return "R5";
        return rne ? "R3" : "R4";
    endfunction

    task automatic check_one(input string tag, input logic [W+2:0] got,
                             input logic [W+2:0] expv, input logic [W-1:0] x,
                             input logic [W-1:0] y);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, x, y, got, expv);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        logic [W+2:0] g_r, g_t, e_r, e_t;
        // Start-up state: zero operands give +0 with no flags (R11)
        #1;
        check_one("R11", {ov_rne, un_rne, iv_rne, p_rne}, 11'h000, a, b);
        // R1 layout: 1.0 is 0_0111_000; R12: result follows within one time step
        a = 8'h38; b = 8'h38; #1;
        check_one("R1", {ov_rne, un_rne, iv_rne, p_rne}, {3'b000, 8'h38}, a, b);
        a = 8'h3C; b = 8'h3C; #1;   // 1.5 * 1.5 = 2.25 = 0_1000_001
        check_one("R12", {ov_rne, un_rne, iv_rne, p_rne}, {3'b000, 8'h41}, a, b);
        // Full sweep of both rounding variants: R2 to R11
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(posedge clk);
                a = W'(ia);
                b = W'(ib);
                @(negedge clk);
                g_r = {ov_rne, un_rne, iv_rne, p_rne};
                g_t = {ov_trn, un_trn, iv_trn, p_trn};
                e_r = ref_mul(a, b, 1'b1);
                e_t = ref_mul(a, b, 1'b0);
                check_one(req_tag(a, b, e_r, g_r, 1'b1), g_r, e_r, a, b);
                check_one(req_tag(a, b, e_t, g_t, 1'b0), g_t, e_t, a, b);
            end
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule